// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches 24 general-purpose input pins arranged as three groups of eight. Each pin first crosses into the clock domain through a two-flop synchroniser. A change in either direction on any pin that software has enabled then sets that group's single flag. Each group raises its own interrupt request when three things are true: its flag is set, its group enable is set, and the global interrupt enable is high.

Software reaches the block over a byte-wide register port with address, write data, write strobe, read strobe and registered read data. Through it, software programs one mask byte per group and the three group enable bits, and it reads the flags back. A flag clears in two ways: software writes a one to the flag bit, or the CPU pulses the acknowledge line for that group when it enters the matching vector. When a new pin event arrives in the same cycle as a clear, the event wins.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, all mask bits, group flags, enable bits, `irq_o` and `rdata_o` are zero.
- R2: A rising or a falling level change on a pin whose mask bit is set sets the group flag. The flag is set on the third rising clock edge after the change (two synchroniser stages plus one detection stage).
- R3: A change on a pin whose mask bit is clear never sets the flag. Setting the mask bit later does not set it either.
- R4: `irq_o[g]` is a register. At each clock edge it loads (flag g AND enable g AND `gie_i`), one cycle behind the flag, and it stays high as long as that condition holds.
- R5: Writing byte address 0x40 with bit g = 1 clears flag g. A write with bit g = 0 leaves flag g unchanged.
- R6: A one-cycle pulse on `ack_i[g]` clears flag g.
- R7: If a masked-in change is detected in the same cycle as a clear (write-one or acknowledge), the flag stays set.
- R8: Group g covers pins 8g+7 down to 8g, and its mask register is at byte address 0x6B+g. Mask bit b enables pin 8g+b.
- R9: Bit 7 of the group-1 mask (address 0x6C) always reads zero and ignores writes, so pin 15 never sets a flag.
- R10: A read loads `rdata_o` on the clock edge where `re_i` is high. Address 0x40 returns the flags in bits 2:0, address 0x41 returns the enables in bits 2:0, and unmapped addresses return zero. `rdata_o` holds its value while `re_i` is low.
- R11: Bits 2:0 of the enable register at address 0x41 are written from `wdata_i[2:0]`, and a read returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 24 | Asynchronous pin inputs |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Register write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 3 | Per-group vector-entry acknowledge |
| irq_o | output | 3 | Per-group interrupt request |

## Verification
The bench times pin edges so that detection lands exactly on an acknowledge pulse. A design that let the clear win would drop that event and read back a zero flag. The bench toggles pins while their mask bits are clear and only afterwards enables them. A design that latched raw changes, or compared against a stale value, would raise a flag late. Writes of zero to the flag register, writes to the reserved group-1 bit and toggles on pin 15 are all checked for having no effect. A behavioural model compared on every clock catches a request that arrives one cycle early or late.

// File: rtl/pcic_pkg.sv
package pcic_pkg;
  localparam int DW = 8;
  localparam int GW = 8;
  localparam logic [DW-1:0] MASK_BASE = 8'h6B;
  localparam logic [DW-1:0] FLAG_ADDR = 8'h40;
  localparam logic [DW-1:0] EN_ADDR   = 8'h41;

  // implemented mask bits per group; group 1 bit 7 is reserved
  function automatic logic [GW-1:0] impl_bits(int g);
    return (g == 1) ? 8'h7F : 8'hFF;
  endfunction
endpackage

// File: rtl/pcic_sync.sv
module pcic_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign chg_o = s2_q ^ prev_q;
endmodule

// File: rtl/pcic_group.sv
module pcic_group #(
  parameter int             GW   = 8,
  parameter logic [GW-1:0]  IMPL = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [GW-1:0] chg_i,
  input  logic          mask_we_i,
  input  logic [GW-1:0] wdata_i,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          gie_i,
  output logic [GW-1:0] mask_o,
  output logic          flag_o,
  output logic          irq_o
);
  logic [GW-1:0] mask_q;
  logic          flag_q, irq_q, hit;

  assign hit = |(chg_i & mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i & IMPL;
      // new event beats a simultaneous clear
      flag_q <= hit | (flag_q & ~clr_i);
      irq_q  <= flag_q & en_i & gie_i;
    end
  end

  assign mask_o = mask_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  p_flag_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_o);
  p_masked_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit && !flag_o && !clr_i) |=> !flag_o);
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !flag_o);
  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit) |=> flag_o);
  p_irq_lag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && en_i && gie_i) |=> irq_o);
  p_irq_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_o && en_i && gie_i) |=> !irq_o);
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pcic_pkg::*;
#(
  parameter int NGRP = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NGRP*GW-1:0] pin_i,
  input  logic [DW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [DW-1:0]      rdata_o,
  input  logic               gie_i,
  input  logic [NGRP-1:0]    ack_i,
  output logic [NGRP-1:0]    irq_o
);
  localparam int NPIN = NGRP * GW;

  logic [NPIN-1:0] chg;
  logic [NGRP-1:0] en_q, flag_w, clr, mask_we;
  logic [GW-1:0]   mask_w [NGRP];
  logic [DW-1:0]   rd_val, rdata_q;

  pcic_sync #(.W(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .chg_o (chg)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign mask_we[g] = we_i && (addr_i == DW'(MASK_BASE + g));
    assign clr[g]     = (we_i && (addr_i == FLAG_ADDR) && wdata_i[g]) || ack_i[g];

    pcic_group #(.GW(GW), .IMPL(impl_bits(g))) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .chg_i    (chg[g*GW +: GW]),
      .mask_we_i(mask_we[g]),
      .wdata_i  (wdata_i[GW-1:0]),
      .clr_i    (clr[g]),
      .en_i     (en_q[g]),
      .gie_i    (gie_i),
      .mask_o   (mask_w[g]),
      .flag_o   (flag_w[g]),
      .irq_o    (irq_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (we_i && addr_i == EN_ADDR) en_q <= wdata_i[NGRP-1:0];
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == FLAG_ADDR) rd_val[NGRP-1:0] = flag_w;
    if (addr_i == EN_ADDR)   rd_val[NGRP-1:0] = en_q;
    for (int g = 0; g < NGRP; g++)
      if (addr_i == DW'(MASK_BASE + g)) rd_val = DW'(mask_w[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  p_en_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == EN_ADDR && re_i == 1'b0) |=> (en_q == $past(wdata_i[NGRP-1:0])));

  if (NGRP > 1) begin : g_rsvd
    p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (re_i && addr_i == DW'(MASK_BASE + 1)) |=> !rdata_o[7]);
  end
endmodule

// File: tb/tb_pin_change_irq.sv
module tb_pin_change_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pins = '0;
  logic [7:0]  addr = '0, wdata = '0;
  logic        we = 1'b0, re = 1'b0, gie = 1'b0;
  logic [2:0]  ack = '0;
  logic [7:0]  rdata;
  logic [2:0]  irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_change_irq dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .gie_i(gie), .ack_i(ack), .irq_o(irq)
  );

  // behavioural reference model
  bit [23:0] m_s1, m_s2, m_prev;
  bit [7:0]  m_mask [3];
  bit [2:0]  m_en, m_flag, m_irq;
  bit [7:0]  m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_en = 0; m_flag = 0; m_irq = 0; m_rd = 0;
      for (int g = 0; g < 3; g++) m_mask[g] = 0;
    end else begin
      bit [23:0] c;
      bit [2:0]  nf;
      bit [7:0]  rv;
      c = m_s2 ^ m_prev;
      rv = 0;
      if (addr == 8'h40) rv = {5'b0, m_flag};
      else if (addr == 8'h41) rv = {5'b0, m_en};
      else if (addr >= 8'h6B && addr <= 8'h6D) rv = m_mask[addr - 8'h6B];
      for (int g = 0; g < 3; g++) begin
        bit hit, cl;
        hit = ((c >> (8*g)) & 24'hFF & m_mask[g]) != 0;
        cl  = (we && addr == 8'h40 && wdata[g]) || ack[g];
        nf[g] = hit || (m_flag[g] && !cl);
      end
      m_irq = m_flag & m_en & {3{gie}};
      m_flag = nf;
      if (re) m_rd = rv;
      if (we) begin
        if (addr == 8'h41) m_en = wdata[2:0];
        for (int g = 0; g < 3; g++)
          if (addr == 8'h6B + g) m_mask[g] = (g == 1) ? (wdata & 8'h7F) : wdata;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R4 irq vs model", irq, m_irq);
    chk("R10 rdata vs model", rdata, m_rd);
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    idle(1);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    addr = a; re = 1'b1;
    idle(1);
    v = rdata; re = 1'b0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    chk("R1 rdata after reset", rdata, 0);
    rd(8'h6B, v); chk("R1 mask0 reset", v, 0);
    rd(8'h6D, v); chk("R1 mask2 reset", v, 0);
    rd(8'h40, v); chk("R1 flags reset", v, 0);
    rd(8'h41, v); chk("R1 enables reset", v, 0);

    // R11 enable register
    wr(8'h41, 8'hFD);
    rd(8'h41, v); chk("R11 enable readback", v, 8'h05);
    wr(8'h41, 8'h07);
    gie = 1'b1;

    // R2 rising edge on masked-in pin 0
    wr(8'h6B, 8'h01);
    pins[0] = 1'b1;
    idle(2);
    chk("R2 no flag before 3rd edge", irq[0], 0);
    idle(1);
    rd(8'h40, v); chk("R2 flag after rise", v, 8'h01);
    chk("R4 irq follows flag", irq[0], 1);

    // R5 write zero ignored, write one clears
    wr(8'h40, 8'h00);
    rd(8'h40, v); chk("R5 write zero keeps flag", v, 8'h01);
    wr(8'h40, 8'h01);
    rd(8'h40, v); chk("R5 write one clears", v, 8'h00);
    idle(1);
    chk("R4 irq drops after clear", irq[0], 0);

    // R2 falling edge, R6 acknowledge clear
    pins[0] = 1'b0;
    idle(4);
    rd(8'h40, v); chk("R2 flag after fall", v, 8'h01);
    ack[0] = 1'b1; idle(1); ack[0] = 1'b0;
    rd(8'h40, v); chk("R6 ack clears", v, 8'h00);

    // R3 change while masked out, then mask enabled later
    pins[1] = 1'b1;
    idle(5);
    wr(8'h6B, 8'h03);
    idle(3);
    rd(8'h40, v); chk("R3 masked-out change ignored", v, 8'h00);

    // R8 group mapping
    wr(8'h6D, 8'h08);
    pins[11] = 1'b1;
    idle(4);
    rd(8'h40, v); chk("R8 pin11 with mask1 clear", v, 8'h00);
    pins[19] = 1'b1;
    idle(4);
    rd(8'h40, v); chk("R8 pin19 sets group 2", v, 8'h04);
    wr(8'h40, 8'h04);

    // R9 reserved bit and pin 15
    wr(8'h6C, 8'hFF);
    rd(8'h6C, v); chk("R9 reserved bit reads zero", v, 8'h7F);
    pins[15] = 1'b1;
    idle(5);
    rd(8'h40, v); chk("R9 pin15 never triggers", v, 8'h00);
    pins[8] = 1'b1;
    idle(4);
    rd(8'h40, v); chk("R8 pin8 sets group 1", v, 8'h02);
    wr(8'h40, 8'h02);

    // R7 set wins over simultaneous ack and write-one
    pins[0] = 1'b1;
    idle(4);
    pins[0] = 1'b0;
    idle(2);
    ack[0] = 1'b1; idle(1); ack[0] = 1'b0;
    rd(8'h40, v); chk("R7 event beats ack", v, 8'h01);
    pins[1] = 1'b0;
    idle(2);
    wr(8'h40, 8'h01);
    rd(8'h40, v); chk("R7 event beats write-one", v, 8'h01);

    // R4 gating by gie and enable
    gie = 1'b0;
    idle(2);
    chk("R4 gie low masks irq", irq[0], 0);
    gie = 1'b1;
    wr(8'h41, 8'h06);
    idle(1);
    chk("R4 group enable low masks irq", irq[0], 0);
    wr(8'h41, 8'h07);
    idle(1);
    chk("R4 irq returns", irq[0], 1);

    // R10 unmapped read and hold
    rd(8'h55, v); chk("R10 unmapped reads zero", v, 0);
    addr = 8'h41;
    idle(3);
    chk("R10 rdata holds without re", rdata, 0);

    idle(2);
    done = 1;
    report();
    $finish;
  end
endmodule